// File: doc/BRIEF.md
# SMRAM access routing decoder

This block sits on the host memory request path. It holds the control state for the System Management RAM window and decides where each host memory request that falls inside that window goes. Each request carries an address, a flag that says whether it is a code fetch or a data reference, and a flag that says whether the issuing processor is in System Management Mode (SMM). The block returns a registered routing code: DRAM, the compatibility PCI bus, or normal decoding. Normal decoding means the rest of the memory map decides where the request goes.

A single configuration write port sets the master enable, three access controls (open, closed, lock), the window base and the window size. Base and size both move in 64 KB steps. The lock control cannot be cleared once it is set, which protects the window after firmware has initialised it. A read-back port shows the stored control word.

Top module: `smram_router`

## Requirements
- R1: After reset, `cfg_rdata` reads enable=0, open=0, closed=0, lock=0, base segment 0x000A (address A0000h) and size code 0 (one 64 KB block). `route_valid` is 0.
- R2: While the master enable (`cfg_wdata`/`cfg_rdata` bit 0) is 0, every request is routed NORMAL (code 2'b00).
- R3: The window covers segments `base` through `base + size_code`. A segment is address bits [31:16]. The base is held in bits [27:12] and the size code in bits [11:4]. A request whose segment lies outside this range is routed NORMAL.
- R4: With enable=1, open (bit 1)=0 and closed (bit 2)=0, an in-window request from a processor in SMM is routed DRAM (2'b01). One from a processor not in SMM is routed PCI (2'b10).
- R5: With enable=1, open=0 and closed=1, an in-window code fetch from a processor in SMM is routed DRAM. Its in-window data references are routed PCI. Every in-window request from a processor not in SMM is routed PCI.
- R6: With enable=1 and open=1 (lock clear), every in-window request is routed DRAM, for code and data alike and whatever the SMM state.
- R7: Writing 1 to lock (bit 3) sets it until reset. While lock is set, open reads 0 and writes of open have no effect on routing.
- R8: While lock is set, writes to the base and size fields are ignored. Enable and closed stay writable.
- R9: `route_valid` rises exactly one clock after a cycle with `req_valid` high, and `route` then carries the decision for that request. Code 2'b11 never appears.
- R10: The window can be relocated and enlarged in 64 KB steps: a new base and size code take effect for the requests that follow the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 28 | Configuration word to write |
| cfg_rdata | output | 28 | Stored configuration word |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_code | input | 1 | 1 = code fetch, 0 = data reference |
| req_smm | input | 1 | 1 = requesting processor is in SMM |
| route_valid | output | 1 | Routing result valid |
| route | output | 2 | 00 normal, 01 DRAM, 10 PCI |

## Verification
The hardest state to reach is the locked state. It can be left only through reset, so it must be exercised last, after the unlocked combinations have been covered.

The bench first walks every combination of open, closed, SMM state and access type in a vector table. It then relocates and grows the window and probes addresses just inside and just outside both edges. Only then does it write lock together with open=1. It confirms at the ports that open reads 0, that later writes to base and size are rejected, and that closed can still be changed.

// File: rtl/smram_pkg.sv
package smram_pkg;
    typedef enum logic [1:0] {
        ROUTE_NORMAL = 2'b00,
        ROUTE_DRAM   = 2'b01,
        ROUTE_PCI    = 2'b10
    } route_e;

    localparam int BIT_EN     = 0;
    localparam int BIT_OPEN   = 1;
    localparam int BIT_CLOSED = 2;
    localparam int BIT_LOCK   = 3;
    localparam int CTRL_BITS  = 4;
endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg #(
    parameter int SEG_W          = 16,
    parameter int SIZE_W         = 8,
    parameter int RESET_BASE_SEG = 'hA,
    localparam int CFG_W         = smram_pkg::CTRL_BITS + SIZE_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output logic              en_o,
    output logic              open_o,
    output logic              closed_o,
    output logic              lock_o,
    output logic [SEG_W-1:0]  base_o,
    output logic [SIZE_W-1:0] size_o
);
    import smram_pkg::*;

    localparam int SIZE_LO = CTRL_BITS;
    localparam int BASE_LO = CTRL_BITS + SIZE_W;

    typedef struct packed {
        logic              en;
        logic              open;
        logic              closed;
        logic              lock;
        logic [SEG_W-1:0]  base;
        logic [SIZE_W-1:0] size;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.en     = wr_data[BIT_EN];
            cfg_d.closed = wr_data[BIT_CLOSED];
            cfg_d.lock   = cfg_q.lock | wr_data[BIT_LOCK];
            // open can never coexist with lock
            cfg_d.open   = cfg_q.lock ? 1'b0 : (wr_data[BIT_OPEN] & ~wr_data[BIT_LOCK]);
            if (!cfg_q.lock) begin
                cfg_d.base = wr_data[BASE_LO +: SEG_W];
                cfg_d.size = wr_data[SIZE_LO +: SIZE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en     <= 1'b0;
            cfg_q.open   <= 1'b0;
            cfg_q.closed <= 1'b0;
            cfg_q.lock   <= 1'b0;
            cfg_q.base   <= SEG_W'(RESET_BASE_SEG);
            cfg_q.size   <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o     = cfg_q.en;
    assign open_o   = cfg_q.open;
    assign closed_o = cfg_q.closed;
    assign lock_o   = cfg_q.lock;
    assign base_o   = cfg_q.base;
    assign size_o   = cfg_q.size;
endmodule

// File: rtl/smram_window_match.sv
module smram_window_match #(
    parameter int SEG_W  = 16,
    parameter int SIZE_W = 8
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [SEG_W-1:0]  base_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              hit_o
);
    logic [SEG_W-1:0] offset;

    // offset form avoids wrap when base + size passes the top of memory
    always_comb begin
        offset = seg_i - base_i;
        hit_o  = (seg_i >= base_i) && (offset <= SEG_W'(size_i));
    end
endmodule

// File: rtl/smram_route_policy.sv
module smram_route_policy (
    input  logic               en_i,
    input  logic               open_i,
    input  logic               closed_i,
    input  logic               hit_i,
    input  logic               smm_i,
    input  logic               code_i,
    output smram_pkg::route_e  route_o
);
    import smram_pkg::*;

    always_comb begin
        if (!en_i || !hit_i) begin
            route_o = ROUTE_NORMAL;
        end else if (open_i) begin
            route_o = ROUTE_DRAM;
        end else if (!smm_i) begin
            route_o = ROUTE_PCI;
        end else if (closed_i && !code_i) begin
            route_o = ROUTE_PCI;
        end else begin
            route_o = ROUTE_DRAM;
        end
    end
endmodule

// File: rtl/smram_router.sv
module smram_router #(
    parameter int ADDR_W         = 32,
    parameter int GRAN_BITS      = 16,
    parameter int SIZE_W         = 8,
    parameter int RESET_BASE_SEG = 'hA,
    localparam int SEG_W         = ADDR_W - GRAN_BITS,
    localparam int CFG_W         = smram_pkg::CTRL_BITS + SIZE_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_code,
    input  logic              req_smm,
    output logic              route_valid,
    output logic [1:0]        route
);
    import smram_pkg::*;

    logic              en, open_c, closed, lock;
    logic [SEG_W-1:0]  base;
    logic [SIZE_W-1:0] size;
    logic              hit;
    route_e            decision;

    smram_cfg_reg #(
        .SEG_W(SEG_W), .SIZE_W(SIZE_W), .RESET_BASE_SEG(RESET_BASE_SEG)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .en_o(en), .open_o(open_c), .closed_o(closed), .lock_o(lock),
        .base_o(base), .size_o(size)
    );

    smram_window_match #(.SEG_W(SEG_W), .SIZE_W(SIZE_W)) u_win (
        .seg_i(req_addr[ADDR_W-1:GRAN_BITS]), .base_i(base), .size_i(size),
        .hit_o(hit)
    );

    smram_route_policy u_pol (
        .en_i(en), .open_i(open_c), .closed_i(closed), .hit_i(hit),
        .smm_i(req_smm), .code_i(req_code), .route_o(decision)
    );

    assign cfg_rdata = {base, size, lock, closed, open_c, en};

    typedef struct packed {
        logic   valid;
        route_e code;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.valid = req_valid;
        out_d.code  = req_valid ? decision : ROUTE_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.valid <= 1'b0;
            out_q.code  <= ROUTE_NORMAL;
        end else begin
            out_q <= out_d;
        end
    end

    assign route_valid = out_q.valid;
    assign route       = out_q.code;
endmodule

// File: rtl/smram_router_checker.sv
module smram_router_checker #(
    parameter int CFG_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_smm,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             route_valid,
    input logic [1:0]       route
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> route_valid);
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !route_valid);
    a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> route != 2'b11);
    a_r2_normal_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_rdata[0]) |=> route == 2'b00);
    a_r4_outsider_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_smm && !cfg_rdata[1]) |=> route != 2'b01);
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] |=> cfg_rdata[3]);
    a_r7_open_clear_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] |-> !cfg_rdata[1]);
    a_r8_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[3] |=> $stable(cfg_rdata[CFG_W-1:4]));
endmodule

bind smram_router smram_router_checker #(.CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_smm(req_smm),
    .cfg_rdata(cfg_rdata), .route_valid(route_valid), .route(route)
);

// File: tb/tb_smram_router.sv
`timescale 1ns/1ps
module tb_smram_router;
    localparam logic [1:0] NRM = 2'b00, DRM = 2'b01, PCI = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [27:0] cfg_wdata = '0;
    logic [27:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_code = 1'b0;
    logic        req_smm = 1'b0;
    logic        route_valid;
    logic [1:0]  route;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    smram_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_code(req_code), .req_smm(req_smm), .route_valid(route_valid),
        .route(route)
    );

    // {open, closed, smm, code, expected route} with enable=1, lock=0
    localparam logic [5:0] VEC [16] = '{
        6'b0000_10, 6'b0001_10, 6'b0010_01, 6'b0011_01,
        6'b0100_10, 6'b0101_10, 6'b0110_10, 6'b0111_01,
        6'b1000_01, 6'b1001_01, 6'b1010_01, 6'b1011_01,
        6'b1100_01, 6'b1101_01, 6'b1110_01, 6'b1111_01
    };

    function automatic logic [27:0] word(input logic [15:0] base, input logic [7:0] size,
                                         input logic lk, input logic cl,
                                         input logic op, input logic en);
        return {base, size, lk, cl, op, en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [27:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(input string tag, input logic [31:0] a, input logic smm,
                       input logic code, input logic [1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_smm = smm; req_code = code;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(route_valid), 32'd1);
        check(tag, 32'(route), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg", 32'(cfg_rdata), 32'(word(16'h000A, 8'h00, 0, 0, 0, 0)));
        check("R1 valid", 32'(route_valid), 32'd0);

        // R2 disabled: window address goes normal
        req("R2 smm", 32'h000A_1234, 1, 1, NRM);
        req("R2 non", 32'h000A_0000, 0, 0, NRM);

        // Table walk, default window, enable set (R4 R5 R6)
        for (int i = 0; i < 16; i++) begin
            wr(word(16'h000A, 8'h00, 0, VEC[i][4], VEC[i][5], 1));
            req($sformatf("R4/R5/R6 vec%0d", i), 32'h000A_8000,
                VEC[i][3], VEC[i][2], VEC[i][1:0]);
        end

        // R3 outside default window
        wr(word(16'h000A, 8'h00, 0, 0, 0, 1));
        req("R3 below", 32'h0009_FFFF, 1, 0, NRM);
        req("R3 above", 32'h000B_0000, 1, 0, NRM);
        req("R3 top edge", 32'h000A_FFFF, 1, 0, DRM);

        // R10 relocate to segment 0x10, four blocks
        wr(word(16'h0010, 8'h03, 0, 0, 0, 1));
        check("R10 cfg", 32'(cfg_rdata), 32'(word(16'h0010, 8'h03, 0, 0, 0, 1)));
        req("R10 old base", 32'h000A_0000, 1, 0, NRM);
        req("R10 first", 32'h0010_0000, 0, 0, PCI);
        req("R10 last", 32'h0013_FFFF, 1, 1, DRM);
        req("R10 past end", 32'h0014_0000, 1, 1, NRM);
        req("R10 before", 32'h000F_FFFF, 1, 1, NRM);

        // R7 lock written together with open=1
        wr(word(16'h0020, 8'h01, 1, 0, 1, 1));
        check("R7 open cleared", 32'(cfg_rdata[1]), 32'd0);
        check("R7 locked", 32'(cfg_rdata[3]), 32'd1);
        req("R7 outsider", 32'h0020_0000, 0, 0, PCI);
        // try to unlock, open, move
        wr(word(16'h0040, 8'h07, 0, 0, 1, 1));
        check("R7 still locked", 32'(cfg_rdata[3]), 32'd1);
        check("R7 open ignored", 32'(cfg_rdata[1]), 32'd0);
        check("R8 base kept", 32'(cfg_rdata[27:12]), 32'h0020);
        check("R8 size kept", 32'(cfg_rdata[11:4]), 32'h01);
        req("R7 outsider again", 32'h0021_0000, 0, 1, PCI);
        req("R8 moved addr", 32'h0040_0000, 1, 1, NRM);
        // R8 closed still writable
        wr(word(16'h0020, 8'h01, 1, 1, 0, 1));
        check("R8 closed taken", 32'(cfg_rdata[2]), 32'd1);
        req("R8 closed data", 32'h0020_0010, 1, 0, PCI);
        req("R8 closed code", 32'h0020_0010, 1, 1, DRM);
        // R8 enable still writable, R2 under lock
        wr(word(16'h0020, 8'h01, 1, 1, 0, 0));
        check("R8 enable taken", 32'(cfg_rdata[0]), 32'd0);
        req("R2 locked off", 32'h0020_0010, 1, 1, NRM);

        // R1 reset clears lock
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 32'(cfg_rdata), 32'(word(16'h000A, 8'h00, 0, 0, 0, 0)));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule